// File: doc/BRIEF.md
# PCI Master Read Command Decoder

This block sits between the user logic and a PCI master engine. For each read command the user logic presents a burst length in 64-bit words, eight read byte enables, a start address and a flag that asks the block to reuse the last burst length. One cycle later the block returns the decoded command. The decoded command gives the effective 64-bit word count, the start address after any dword shift, whether the read runs as a burst or as a single access, and how many PCI data transfers the read will take. An error flag marks commands that break the read rules.

Two static configuration inputs shape the decode. The first selects a 32-bit or 64-bit PCI data path. The second selects the quad-port or dual-port user interface. Reusing the stored length saves a command-phase cycle in quad-port mode. That saving does not exist in dual-port mode, so a reuse request there is an error.

Top module: `pci_rdcmd_decoder`

## Requirements
- R1: After reset, `res_valid` and `cmd_err` are 0 and the stored previous burst length is 1, so a reuse request as the first command yields `word_count` = 1.
- R2: Each cycle with `cmd_valid` = 1 produces `res_valid` = 1 on the next cycle, holding that command's decode. A cycle without `cmd_valid` gives `res_valid` = 0 on the next cycle.
- R3: With `reuse_len` = 1 the `burst_len` input is ignored and `word_count` equals the length of the last command decoded without error. With `reuse_len` = 0, `word_count` equals `burst_len`.
- R4: The stored length is replaced only by commands decoded with `cmd_err` = 0.
- R5: The read is a burst (`is_burst` = 1) when the effective length is greater than 1, or when all eight byte enables are 1 (`rd_be` = 8'hFF) on a 32-bit bus (`bus_is_64` = 0). Otherwise it is a single access.
- R6: A burst takes 2 x length transfers on a 32-bit bus and length transfers on a 64-bit bus. A single access takes exactly 1 transfer.
- R7: For a single access on a 32-bit bus, `rd_be[3:0]` = 4'hF moves `eff_addr` up by 4 (for example, `rd_be` = 8'h0F). `rd_be[3:0]` = 4'h0 leaves it unchanged (for example, 8'hF0). On a 64-bit bus, or for a burst, `eff_addr` equals `start_addr`.
- R8: `cmd_err` is 1 when `start_addr[2]` = 1 (the address is not 64-bit aligned).
- R9: `cmd_err` is 1 when `reuse_len` = 1 while `quad_port` = 0 (dual-port mode).
- R10: `cmd_err` is 1 for a burst whose byte enables are not all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_is_64 | input | 1 | 1 = 64-bit PCI data path, 0 = 32-bit |
| quad_port | input | 1 | 1 = quad-port user interface, 0 = dual-port |
| cmd_valid | input | 1 | A command is presented this cycle |
| reuse_len | input | 1 | Take the stored previous length instead of `burst_len` |
| burst_len | input | LEN_W | Requested length in 64-bit words |
| rd_be | input | 8 | Read byte enables, bit i = byte lane i |
| start_addr | input | ADDR_W | Byte start address |
| res_valid | output | 1 | Decode result valid |
| word_count | output | LEN_W | Effective length in 64-bit words |
| eff_addr | output | ADDR_W | Start address after dword adjustment |
| is_burst | output | 1 | 1 = burst read, 0 = single access |
| xfer_count | output | LEN_W+1 | Number of PCI data transfers |
| cmd_err | output | 1 | Command breaks a read rule |

## Verification
The only state this block keeps is the stored length, and it shows at the ports only when a later command sets `reuse_len`. A stored length that is corrupted, or one that an erroring command updates by mistake, therefore stays hidden until the next reuse. It then appears one cycle later as a wrong `word_count` and a wrong `xfer_count`. The stimulus places reuse commands directly after good commands, after bad commands and after a reset, so such faults surface within one or two commands. Decode faults in the mode, address or error logic have no memory, and they show on the result that follows the offending command.

// File: rtl/rdcmd_pkg.sv
package rdcmd_pkg;

  localparam int BE_W = 8;
  localparam logic [BE_W-1:0] BE_ALL = {BE_W{1'b1}};
  localparam int DWORD_BYTES = 4;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BURST  = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic dual_reuse;
    logic misalign;
    logic partial_be;
  } err_cause_t;

  // Burst when length exceeds one, or all lanes enabled on a 32-bit path.
  function automatic rd_mode_e pick_mode(input logic len_gt1,
                                         input logic be_full,
                                         input logic bus64);
    if (len_gt1 || (be_full && !bus64)) return MODE_BURST;
    return MODE_SINGLE;
  endfunction

  // Lower dword lanes enabled on a 32-bit single read selects the upper dword.
  function automatic logic upper_dword_sel(input logic [BE_W-1:0] be,
                                           input logic bus64,
                                           input rd_mode_e mode);
    return (mode == MODE_SINGLE) && !bus64 && (be[3:0] == 4'hF);
  endfunction

endpackage

// File: rtl/rdcmd_len_store.sv
module rdcmd_len_store #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [LEN_W-1:0] new_len,
  output logic [LEN_W-1:0] prev_len
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= LEN_ONE;
    end else if (upd) begin
      len_q <= new_len;
    end
  end

  assign prev_len = len_q;

endmodule

// File: rtl/rdcmd_classify.sv
module rdcmd_classify
  import rdcmd_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic [LEN_W-1:0] eff_len,
  input  logic [BE_W-1:0]  rd_be,
  input  logic             bus_is_64,
  input  logic             quad_port,
  input  logic             reuse_len,
  input  logic             addr_b2,
  output rd_mode_e         mode,
  output logic [LEN_W:0]   xfers,
  output err_cause_t       cause
);

  localparam int XFER_W = LEN_W + 1;

  function automatic logic [XFER_W-1:0] count_xfers(input logic [LEN_W-1:0] len,
                                                   input logic bus64,
                                                   input rd_mode_e m);
    if (m == MODE_SINGLE) return XFER_W'(1);
    if (bus64) return {1'b0, len};
    return {len, 1'b0};
  endfunction

  logic len_gt1;
  logic be_full;

  assign len_gt1 = (eff_len > LEN_W'(1));
  assign be_full = (rd_be == BE_ALL);

  always_comb begin
    mode             = pick_mode(len_gt1, be_full, bus_is_64);
    xfers            = count_xfers(eff_len, bus_is_64, mode);
    cause.dual_reuse = reuse_len && !quad_port;
    cause.misalign   = addr_b2;
    cause.partial_be = (mode == MODE_BURST) && !be_full;
  end

endmodule

// File: rtl/rdcmd_addr_align.sv
module rdcmd_addr_align
  import rdcmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [BE_W-1:0]   rd_be,
  input  logic              bus_is_64,
  input  rd_mode_e          mode,
  output logic [ADDR_W-1:0] adj_addr,
  output logic              shifted
);

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a,
                                             input logic sel);
    return sel ? (a + ADDR_W'(DWORD_BYTES)) : a;
  endfunction

  always_comb begin
    shifted  = upper_dword_sel(rd_be, bus_is_64, mode);
    adj_addr = bump(start_addr, shifted);
  end

endmodule

// File: rtl/pci_rdcmd_decoder.sv
module pci_rdcmd_decoder
  import rdcmd_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_is_64,
  input  logic              quad_port,
  input  logic              cmd_valid,
  input  logic              reuse_len,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [7:0]        rd_be,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              res_valid,
  output logic [LEN_W-1:0]  word_count,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              is_burst,
  output logic [LEN_W:0]    xfer_count,
  output logic              cmd_err
);

  localparam int XFER_W = LEN_W + 1;

  // Named internal events, visible to the bound checker.
  logic [LEN_W-1:0]  prev_len;
  logic [LEN_W-1:0]  eff_len;
  rd_mode_e          mode;
  logic [XFER_W-1:0] xfers;
  err_cause_t        cause;
  logic              ev_any_err;
  logic              ev_len_upd;
  logic [ADDR_W-1:0] adj_addr;
  logic              ev_shift;

  assign eff_len    = reuse_len ? prev_len : burst_len;
  assign ev_any_err = |cause;
  assign ev_len_upd = cmd_valid && !ev_any_err;

  rdcmd_len_store #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (ev_len_upd),
    .new_len  (eff_len),
    .prev_len (prev_len)
  );

  rdcmd_classify #(.LEN_W(LEN_W)) u_cls (
    .eff_len   (eff_len),
    .rd_be     (rd_be),
    .bus_is_64 (bus_is_64),
    .quad_port (quad_port),
    .reuse_len (reuse_len),
    .addr_b2   (start_addr[2]),
    .mode      (mode),
    .xfers     (xfers),
    .cause     (cause)
  );

  rdcmd_addr_align #(.ADDR_W(ADDR_W)) u_adr (
    .start_addr (start_addr),
    .rd_be      (rd_be),
    .bus_is_64  (bus_is_64),
    .mode       (mode),
    .adj_addr   (adj_addr),
    .shifted    (ev_shift)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      word_count <= '0;
      eff_addr   <= '0;
      is_burst   <= 1'b0;
      xfer_count <= '0;
      cmd_err    <= 1'b0;
    end else begin
      res_valid <= cmd_valid;
      if (cmd_valid) begin
        word_count <= eff_len;
        eff_addr   <= adj_addr;
        is_burst   <= (mode == MODE_BURST);
        xfer_count <= xfers;
        cmd_err    <= ev_any_err;
      end else begin
        cmd_err    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rdcmd_checker.sv
module rdcmd_checker #(
  parameter int LEN_W  = 6,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_is_64,
  input logic              quad_port,
  input logic              cmd_valid,
  input logic              reuse_len,
  input logic [LEN_W-1:0]  burst_len,
  input logic [7:0]        rd_be,
  input logic [ADDR_W-1:0] start_addr,
  input logic              res_valid,
  input logic [LEN_W-1:0]  word_count,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              is_burst,
  input logic [LEN_W:0]    xfer_count,
  input logic              cmd_err,
  input logic [LEN_W-1:0]  prev_len
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !res_valid && !cmd_err);

  a_r3_reuse_takes_prev: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && reuse_len |=> word_count == $past(prev_len));

  a_r3_fresh_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !reuse_len |=> word_count == $past(burst_len));

  a_r4_err_keeps_len: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cmd_err |-> $stable(prev_len));

  a_r6_wide_single_one: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !is_burst |-> xfer_count == (LEN_W+1)'(1));

  a_r8_misalign_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && start_addr[2] |=> cmd_err);

  a_r9_dual_reuse_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && reuse_len && !quad_port |=> cmd_err);

  a_r7_burst_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && bus_is_64 |=> eff_addr == $past(start_addr));

endmodule

bind pci_rdcmd_decoder rdcmd_checker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_rdcmd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_is_64  (bus_is_64),
  .quad_port  (quad_port),
  .cmd_valid  (cmd_valid),
  .reuse_len  (reuse_len),
  .burst_len  (burst_len),
  .rd_be      (rd_be),
  .start_addr (start_addr),
  .res_valid  (res_valid),
  .word_count (word_count),
  .eff_addr   (eff_addr),
  .is_burst   (is_burst),
  .xfer_count (xfer_count),
  .cmd_err    (cmd_err),
  .prev_len   (prev_len)
);

// File: tb/pci_rdcmd_decoder_bench.sv
module pci_rdcmd_decoder_bench;

  localparam int LEN_W  = 6;
  localparam int ADDR_W = 32;
  localparam int NVEC   = 12;

  typedef struct packed {
    logic        b64;
    logic        quad;
    logic        reuse;
    logic [7:0]  be;
    logic [5:0]  len;
    logic [31:0] addr;
    logic [5:0]  x_cnt;
    logic [31:0] x_addr;
    logic        x_burst;
    logic [6:0]  x_xfer;
    logic        x_err;
  } vec_t;

  // Walked in order: entries with reuse depend on earlier entries.
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b1,1'b0,8'hFF,6'd4, 32'h1000, 6'd4, 32'h1000,1'b1,7'd8, 1'b0},
    '{1'b1,1'b1,1'b0,8'hFF,6'd4, 32'h2008, 6'd4, 32'h2008,1'b1,7'd4, 1'b0},
    '{1'b0,1'b1,1'b1,8'hFF,6'd9, 32'h3000, 6'd4, 32'h3000,1'b1,7'd8, 1'b0},
    '{1'b0,1'b0,1'b0,8'hF0,6'd1, 32'h4000, 6'd1, 32'h4000,1'b0,7'd1, 1'b0},
    '{1'b0,1'b0,1'b0,8'h0F,6'd1, 32'h4000, 6'd1, 32'h4004,1'b0,7'd1, 1'b0},
    '{1'b1,1'b0,1'b0,8'h0F,6'd1, 32'h5000, 6'd1, 32'h5000,1'b0,7'd1, 1'b0},
    '{1'b0,1'b1,1'b0,8'hFF,6'd1, 32'h6000, 6'd1, 32'h6000,1'b1,7'd2, 1'b0},
    '{1'b0,1'b1,1'b0,8'hFF,6'd2, 32'h7004, 6'd2, 32'h7004,1'b1,7'd4, 1'b1},
    '{1'b0,1'b0,1'b1,8'hFF,6'd5, 32'h8000, 6'd1, 32'h8000,1'b1,7'd2, 1'b1},
    '{1'b1,1'b1,1'b0,8'h3C,6'd3, 32'h9000, 6'd3, 32'h9000,1'b1,7'd3, 1'b1},
    '{1'b1,1'b1,1'b1,8'hFF,6'd7, 32'hA000, 6'd1, 32'hA000,1'b0,7'd1, 1'b0},
    '{1'b0,1'b1,1'b0,8'hFF,6'd32,32'hB000, 6'd32,32'hB000,1'b1,7'd64,1'b0}
  };

  // Requirement covered by each vector, for messages.
  localparam string TAG [NVEC] = '{"R6","R6","R3","R7","R7","R7","R5",
                                   "R8","R9","R10","R4","R6"};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_is_64 = 1'b0;
  logic              quad_port = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              reuse_len = 1'b0;
  logic [LEN_W-1:0]  burst_len = '0;
  logic [7:0]        rd_be = '0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              res_valid;
  logic [LEN_W-1:0]  word_count;
  logic [ADDR_W-1:0] eff_addr;
  logic              is_burst;
  logic [LEN_W:0]    xfer_count;
  logic              cmd_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pci_rdcmd_decoder #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_pci_rdcmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_is_64(bus_is_64), .quad_port(quad_port),
    .cmd_valid(cmd_valid), .reuse_len(reuse_len), .burst_len(burst_len),
    .rd_be(rd_be), .start_addr(start_addr), .res_valid(res_valid),
    .word_count(word_count), .eff_addr(eff_addr), .is_burst(is_burst),
    .xfer_count(xfer_count), .cmd_err(cmd_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic b64, input logic quad, input logic reuse,
                       input logic [7:0] be, input logic [5:0] len,
                       input logic [31:0] addr);
    bus_is_64  = b64;
    quad_port  = quad;
    reuse_len  = reuse;
    rd_be      = be;
    burst_len  = len;
    start_addr = addr;
    cmd_valid  = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "res_valid", 32'(res_valid), 32'd0);
    check("R1", "cmd_err", 32'(cmd_err), 32'd0);
    rst_n = 1'b1;
    // R1: first command reuses the reset length of one
    issue(1'b1, 1'b1, 1'b1, 8'hFF, 6'd12, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1", "word_count", 32'(word_count), 32'd1);
    check("R1", "xfer_count", 32'(xfer_count), 32'd1);
    @(negedge clk);
    check("R2", "res_valid idle", 32'(res_valid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i].b64, VEC[i].quad, VEC[i].reuse, VEC[i].be, VEC[i].len, VEC[i].addr);
      @(negedge clk);
      check("R2", "res_valid", 32'(res_valid), 32'd1);
      check(TAG[i], "word_count", 32'(word_count), 32'(VEC[i].x_cnt));
      check(TAG[i], "eff_addr", eff_addr, VEC[i].x_addr);
      check(TAG[i], "is_burst", 32'(is_burst), 32'(VEC[i].x_burst));
      check(TAG[i], "xfer_count", 32'(xfer_count), 32'(VEC[i].x_xfer));
      check(TAG[i], "cmd_err", 32'(cmd_err), 32'(VEC[i].x_err));
    end
    cmd_valid = 1'b0;

    // R4: length 32 stored; reset brings it back to one (R1)
    issue(1'b1, 1'b1, 1'b1, 8'hFF, 6'd3, 32'hC000);
    @(negedge clk);
    check("R4", "word_count after good", 32'(word_count), 32'd32);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "res_valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    issue(1'b0, 1'b1, 1'b1, 8'hF0, 6'd20, 32'hD000);
    @(negedge clk);
    check("R1", "word_count after reset", 32'(word_count), 32'd1);
    check("R7", "eff_addr low dword", eff_addr, 32'hD000);
    check("R5", "single on 32-bit", 32'(is_burst), 32'd0);
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R2", "cmd_err idle", 32'(cmd_err), 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule